// File: doc/BRIEF.md
# Serial Channel Wait/DMA Request Controller

This block drives the two block-transfer control lines of one serial channel. The main line can act in one of two ways. As a CPU wait line it is open-drain, pulled low only while the processor has to be held off. As a DMA request line it is push-pull and tells a DMA engine that the channel can take or give a character. The auxiliary line is always push-pull and can act only as a transmit DMA request.

Software programs a small mode byte through a configuration write. Bit 7 enables the main line, bit 6 picks wait (0) or DMA request (1), and bit 5 picks receive (1) or transmit (0). Bit 0 enables the auxiliary transmit request. Software should write the selection first and set the enable in a second write. Reset clears the mode byte, which leaves wait mode selected and the line released.

The wait line goes low as soon as a blocked access starts. It is held until the buffer stops blocking, and it is let go on a falling edge of the peripheral clock.

Top module: `wrq_ctrl`

## Requirements
- R1: While reset is active and right after it, the mode byte is 0, the main line is released (`wreq_oe`=0) and `aux_req_n` is 1.
- R2: While mode bit 7 is 0, the main line stays released whatever the other mode bits, strobes and buffer flags are.
- R3: In wait-on-transmit mode (bits 7,6,5 = 1,0,0), a CPU write (`cpu_wr`=1) with `reg_sel` equal to the transmit-buffer select (8) while `tx_full`=1 drives the main line low (`wreq_oe`=1, `wreq_o`=0) in the same cycle, with no clock edge in between.
- R4: Once a wait has been latched at a falling clock edge, the line stays low after the strobe ends for as long as the buffer blocks. It is released at the first falling clock edge at which the buffer no longer blocks.
- R5: A write to any other select value, a write while `tx_full`=0, or a read never starts a wait in wait-on-transmit mode.
- R6: In wait-on-receive mode (bits 7,6,5 = 1,0,1), a CPU read (`cpu_rd`=1) with `reg_sel` equal to the receive-buffer select (8) while `rx_empty`=1 drives the line low. R4 applies to it, with `rx_empty` as the blocking flag.
- R7: In DMA mode (bits 7,6 = 1,1) the line is always driven (`wreq_oe`=1). `wreq_o` is 0 (request) while `tx_full`=0 when bit 5 = 0, or while `rx_empty`=0 when bit 5 = 1. Otherwise `wreq_o` is 1.
- R8: `aux_req_n` is 0 exactly when mode bit 0 = 1 and `tx_full`=0. Otherwise it is 1.
- R9: A mode write that leaves wait mode ends any pending wait from the next rising edge. The line then follows the new mode at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; the mode byte loads on the rising edge, wait state is latched on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode byte write strobe |
| cfg_wdata | input | 8 | Mode byte write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| reg_sel | input | 4 | Decoded register select of the current access |
| tx_full | input | 1 | Transmit buffer is full |
| rx_empty | input | 1 | Receive buffer holds no character |
| wreq_oe | output | 1 | Main line driven when 1, released (pulled high) when 0 |
| wreq_o | output | 1 | Main line level while driven |
| aux_req_n | output | 1 | Auxiliary transmit DMA request, active low |

## Verification
A wrongly decoded mode byte shows on the main line in the very cycle of the configuration write. Depending on the fault, the line is driven when it should be released, or it carries the wrong DMA level. A stuck or lost wait latch shows only after a falling clock edge. It appears either as a wait that outlives its blocking flag by more than half a cycle, or as a release while the strobe has ended and the buffer still blocks. Random traffic over the modes exposes both kinds against a bench model. Directed sequences then time the release to the falling edge and test the exit from wait mode.

// File: rtl/wrq_pkg.sv
package wrq_pkg;
  localparam int unsigned EN_POS  = 7;
  localparam int unsigned FN_POS  = 6;
  localparam int unsigned DIR_POS = 5;
  localparam int unsigned AUX_POS = 0;

  typedef struct packed {
    logic en;
    logic fn_dma;
    logic dir_rx;
    logic aux_en;
  } wrq_mode_t;

  typedef struct packed {
    logic wait_tx;
    logic wait_rx;
    logic dma;
  } wrq_func_t;

  function automatic wrq_func_t decode_mode(input wrq_mode_t m);
    wrq_func_t f;
    f.wait_tx = m.en & ~m.fn_dma & ~m.dir_rx;
    f.wait_rx = m.en & ~m.fn_dma &  m.dir_rx;
    f.dma     = m.en &  m.fn_dma;
    return f;
  endfunction

  function automatic logic dma_level(input wrq_mode_t m, input logic txf, input logic rxe);
    logic want;
    want = m.dir_rx ? ~rxe : ~txf;
    return ~want;
  endfunction
endpackage

// File: rtl/wrq_mode_reg.sv
module wrq_mode_reg
  import wrq_pkg::*;
#(
  parameter int unsigned MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_wdata,
  output wrq_mode_t         mode
);
  localparam logic [MODE_W-1:0] USED_MASK =
    (MODE_W'(1) << EN_POS) | (MODE_W'(1) << FN_POS) |
    (MODE_W'(1) << DIR_POS) | (MODE_W'(1) << AUX_POS);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^(cfg_wdata & ~USED_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (cfg_we) begin
      mode.en     <= cfg_wdata[EN_POS];
      mode.fn_dma <= cfg_wdata[FN_POS];
      mode.dir_rx <= cfg_wdata[DIR_POS];
      mode.aux_en <= cfg_wdata[AUX_POS];
    end
  end
endmodule

// File: rtl/wrq_wait_track.sv
module wrq_wait_track (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_ok,
  input  logic trig,
  input  logic blocked,
  output logic hold_q,
  output logic active
);
  logic set_now;
  assign set_now = mode_ok & trig & blocked;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= (hold_q | set_now) & blocked & mode_ok;
  end

  assign active = mode_ok & (set_now | hold_q);
endmodule

// File: rtl/wrq_req_drive.sv
module wrq_req_drive
  import wrq_pkg::*;
(
  input  wrq_mode_t mode,
  input  wrq_func_t func,
  input  logic      wait_on,
  input  logic      tx_full,
  input  logic      rx_empty,
  output logic      wreq_oe,
  output logic      wreq_o,
  output logic      aux_req_n
);
  always_comb begin
    wreq_oe   = wait_on | func.dma;
    wreq_o    = func.dma ? dma_level(mode, tx_full, rx_empty) : 1'b0;
    aux_req_n = ~(mode.aux_en & ~tx_full);
  end
endmodule

// File: rtl/wrq_ctrl.sv
module wrq_ctrl
  import wrq_pkg::*;
#(
  parameter int unsigned MODE_W = 8,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned TX_SEL = 8,
  parameter int unsigned RX_SEL = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MODE_W-1:0] cfg_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              tx_full,
  input  logic              rx_empty,
  output logic              wreq_oe,
  output logic              wreq_o,
  output logic              aux_req_n
);
  localparam int unsigned NDIR = 2;
  localparam logic [SEL_W-1:0] TXS = SEL_W'(TX_SEL);
  localparam logic [SEL_W-1:0] RXS = SEL_W'(RX_SEL);

  wrq_mode_t mode;
  wrq_func_t func;

  logic [NDIR-1:0] dir_ok, dir_trig, dir_block, dir_hold, dir_act;
  logic            wait_on;

  wrq_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .mode(mode)
  );

  assign func = decode_mode(mode);

  assign dir_ok[0]    = func.wait_tx;
  assign dir_trig[0]  = cpu_wr & (reg_sel == TXS);
  assign dir_block[0] = tx_full;
  assign dir_ok[1]    = func.wait_rx;
  assign dir_trig[1]  = cpu_rd & (reg_sel == RXS);
  assign dir_block[1] = rx_empty;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    wrq_wait_track u_trk (
      .clk(clk), .rst_n(rst_n), .mode_ok(dir_ok[d]), .trig(dir_trig[d]),
      .blocked(dir_block[d]), .hold_q(dir_hold[d]), .active(dir_act[d])
    );
  end

  assign wait_on = |dir_act;

  wrq_req_drive u_drv (
    .mode(mode), .func(func), .wait_on(wait_on), .tx_full(tx_full),
    .rx_empty(rx_empty), .wreq_oe(wreq_oe), .wreq_o(wreq_o), .aux_req_n(aux_req_n)
  );
endmodule

// File: rtl/wrq_ctrl_chk.sv
module wrq_ctrl_chk
  import wrq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input wrq_mode_t       mode,
  input wrq_func_t       func,
  input logic [1:0]      dir_hold,
  input logic [1:0]      dir_trig,
  input logic            tx_full,
  input logic            cfg_we,
  input logic            wreq_oe,
  input logic            wreq_o,
  input logic            aux_req_n
);
  // R1
  reset_release_chk: assert property (@(posedge clk) !rst_n |-> (!wreq_oe && aux_req_n));
  // R2
  disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.en |-> !wreq_oe);
  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (func.wait_tx && dir_hold[0] && !cfg_we) |-> (wreq_oe && !wreq_o));
  // R5
  no_spurious_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (func.wait_tx && !dir_hold[0] && !(dir_trig[0] && tx_full)) |-> !wreq_oe);
  // R7
  dma_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    func.dma |-> wreq_oe);
  // R8
  aux_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.aux_en |-> aux_req_n);
endmodule

bind wrq_ctrl wrq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .func(func), .dir_hold(dir_hold),
  .dir_trig(dir_trig), .tx_full(tx_full), .cfg_we(cfg_we), .wreq_oe(wreq_oe),
  .wreq_o(wreq_o), .aux_req_n(aux_req_n)
);

// File: tb/wrq_ctrl_test.sv
`timescale 1ns/1ps
module wrq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [3:0] reg_sel = '0;
  logic tx_full = 1'b0, rx_empty = 1'b1;
  logic wreq_oe, wreq_o, aux_req_n;

  int checks = 0;
  int fails = 0;
  logic [7:0] m_mode = '0;
  logic m_hold_tx = 1'b0, m_hold_rx = 1'b0;

  always #2.5 clk = ~clk;

  wrq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .reg_sel(reg_sel), .tx_full(tx_full),
    .rx_empty(rx_empty), .wreq_oe(wreq_oe), .wreq_o(wreq_o), .aux_req_n(aux_req_n)
  );

  function automatic logic is_wtx(input logic [7:0] m); return m[7:5] == 3'b100; endfunction
  function automatic logic is_wrx(input logic [7:0] m); return m[7:5] == 3'b101; endfunction
  function automatic logic is_dma(input logic [7:0] m); return m[7:6] == 2'b11; endfunction
  function automatic logic tx_set(); return is_wtx(m_mode) && cpu_wr && reg_sel == 4'd8 && tx_full; endfunction
  function automatic logic rx_set(); return is_wrx(m_mode) && cpu_rd && reg_sel == 4'd8 && rx_empty; endfunction

  // pin level seen with a pull-up: 1 when released
  function automatic logic exp_pin();
    if (is_dma(m_mode)) return m_mode[5] ? rx_empty : tx_full;
    if ((is_wtx(m_mode) && (tx_set() || m_hold_tx)) || (is_wrx(m_mode) && (rx_set() || m_hold_rx))) return 1'b0;
    return 1'b1;
  endfunction
  function automatic logic exp_oe();
    return is_dma(m_mode) || !exp_pin();
  endfunction
  function automatic logic exp_aux(); return !(m_mode[0] && !tx_full); endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_mode <= '0;
    else if (cfg_we) m_mode <= cfg_wdata;

  always @(negedge clk or negedge rst_n)
    if (!rst_n) begin m_hold_tx <= 1'b0; m_hold_rx <= 1'b0; end
    else begin
      m_hold_tx <= (m_hold_tx || tx_set()) && tx_full && is_wtx(m_mode);
      m_hold_rx <= (m_hold_rx || rx_set()) && rx_empty && is_wrx(m_mode);
    end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pin(); return wreq_oe ? wreq_o : 1'b1; endfunction

  task automatic check_all(input string req);
    check(req, pin(), exp_pin());
    check(req, wreq_oe, exp_oe());
    check("R8", aux_req_n, exp_aux());
  endtask

  function automatic string mode_tag();
    if (!m_mode[7]) return "R2";
    if (is_dma(m_mode)) return "R7";
    if (is_wrx(m_mode)) return "R6";
    return "R3";
  endfunction

  task automatic step(); @(posedge clk); #1; endtask

  task automatic cfg(input logic [7:0] v);
    step(); cfg_we = 1'b1; cfg_wdata = v;
    step(); cfg_we = 1'b0;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    #1;
    check("R1", wreq_oe, 1'b0);
    check("R1", aux_req_n, 1'b1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    check("R1", wreq_oe, 1'b0);
    check("R1", aux_req_n, 1'b1);

    // R2: function chosen while disabled gives no activity
    tx_full = 1'b1; cpu_wr = 1'b1; reg_sel = 4'd8;
    cfg(8'h40); #1; check("R2", wreq_oe, 1'b0);
    cfg(8'h00); #1; check("R2", wreq_oe, 1'b0);
    cpu_wr = 1'b0;

    // R3 / R4: wait on transmit, release on falling edge
    cfg(8'h80);
    step(); tx_full = 1'b1; cpu_wr = 1'b1; reg_sel = 4'd8;
    #1 check("R3", pin(), 1'b0);
    step(); cpu_wr = 1'b0;
    #1 check("R4", pin(), 1'b0);
    step(); tx_full = 1'b0;
    #1 check("R4", pin(), 1'b0);
    @(negedge clk); #0.5 check("R4", pin(), 1'b1);

    // R5: wrong select, not full, or a read
    step(); tx_full = 1'b1; cpu_wr = 1'b1; reg_sel = 4'd3;
    #1 check("R5", wreq_oe, 1'b0);
    step(); tx_full = 1'b0; reg_sel = 4'd8;
    #1 check("R5", wreq_oe, 1'b0);
    step(); tx_full = 1'b1; cpu_wr = 1'b0; cpu_rd = 1'b1;
    #1 check("R5", wreq_oe, 1'b0);
    step(); cpu_rd = 1'b0;

    // R6: wait on receive
    cfg(8'hA0);
    step(); rx_empty = 1'b1; cpu_rd = 1'b1; reg_sel = 4'd8;
    #1 check("R6", pin(), 1'b0);
    step(); cpu_rd = 1'b0;
    #1 check("R6", pin(), 1'b0);
    step(); rx_empty = 1'b0;
    @(negedge clk); #0.5 check("R6", pin(), 1'b1);

    // R9: leave wait mode while a wait is pending
    cfg(8'h80);
    step(); tx_full = 1'b1; cpu_wr = 1'b1; reg_sel = 4'd8;
    step(); cpu_wr = 1'b0; #1 check("R9", pin(), 1'b0);
    step(); cfg_we = 1'b1; cfg_wdata = 8'hC0;
    step(); cfg_we = 1'b0;
    #1 check("R9", wreq_oe, 1'b1);
    check("R9", wreq_o, 1'b1);
    tx_full = 1'b0; #0.2 check("R7", wreq_o, 1'b0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      step();
      cfg_we = ($urandom_range(0, 9) == 0);
      case ($urandom_range(0, 8))
        0: cfg_wdata = 8'h00; 1: cfg_wdata = 8'h80; 2: cfg_wdata = 8'hA0;
        3: cfg_wdata = 8'hC0; 4: cfg_wdata = 8'hE1; 5: cfg_wdata = 8'h81;
        6: cfg_wdata = 8'h21; 7: cfg_wdata = 8'h9E;
        default: cfg_wdata = 8'($urandom);
      endcase
      cpu_wr = $urandom_range(0, 1) == 1;
      cpu_rd = $urandom_range(0, 2) == 0;
      reg_sel = ($urandom_range(0, 2) != 0) ? 4'd8 : 4'($urandom);
      if ($urandom_range(0, 3) == 0) tx_full = ~tx_full;
      if ($urandom_range(0, 3) == 0) rx_empty = ~rx_empty;
      #1 check_all(mode_tag());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule